// File: doc/BRIEF.md
# Per-Byte Variable Funnel Shifter

This block shifts each byte lane of a 128-bit vector by its own amount of 0 to 7 bit positions, all lanes to the left or all to the right. It does not fill the vacated positions with zeros. Each lane reads an 8-bit window from a 16-bit pair made of its own byte and the adjacent byte of the same data vector. Zeros enter only at the two outer lanes: the last lane for a left shift and the first lane for a right shift.

Lanes are numbered in big-endian order. Lane 0 is the most significant byte of the vector. Within a byte, position 0 is the most significant bit. Each lane takes its shift amount from the three least significant bits of the matching byte of a second 128-bit vector.

Both directions share one datapath. A valid strobe captures the inputs, and the result appears in a register with its own valid flag one clock later.

Top module: `byte_lane_shifter`

## Requirements
- R1: With `dirRight` = 0 (left), lane i outputs bits s through s+7, counted from the MSB, of the 16-bit pair formed by lane i as the upper byte and lane i+1 as the lower byte. Here s is the lane's shift amount and lane 0 is `dataIn[127:120]`. Data bytes all 0x0F with shift bytes 0x00..0x0F in lane order give 0F1E3C78F0E1C3870F1E3C78F0E1C380.
- R2: With `dirRight` = 1 (right), lane i outputs bits 8−s through 15−s of the pair formed by lane i−1 as the upper byte and lane i as the lower byte. Data bytes all 0x0F with shift bytes 0x0F..0x00 give 003C78F0E1C3870F1E3C78F0E1C3870F.
- R3: Only bits [2:0] of each shift byte set the shift amount. Bits [7:3] have no effect on the result.
- R4: In a left shift, lane 15 uses zero as its following byte. Data 0x0F shifted left by 7 gives 0x80.
- R5: In a right shift, lane 0 uses zero as its preceding byte. Data 0x0F shifted right by 7 gives 0x00.
- R6: A lane whose shift amount is 0 outputs its data byte unchanged in either direction.
- R7: `outValid` is high in exactly the cycle after a clock edge at which `inValid` was high. The result of that capture is visible on `result` in that same cycle.
- R8: When `inValid` is low at an edge, `result` keeps its previous value whatever the other inputs do.
- R9: Synchronous active-high `rst` clears `outValid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Capture strobe for the inputs |
| dirRight | input | 1 | 0 = shift left, 1 = shift right |
| dataIn | input | 128 | Data vector, lane 0 in the top byte |
| shiftIn | input | 128 | Per-lane shift amounts, low 3 bits of each byte |
| result | output | 128 | Registered shifted vector |
| outValid | output | 1 | Result valid, one cycle after capture |

## Verification
The bench applies four kinds of pattern. Uniform 0x0F data with a ramp of shift amounts walks every amount through both directions. Because data flows in from the neighbouring byte, this pattern separates a funnel shift from a zero-filling shift. Uniform amount 7 isolates the edge lanes, where zero-fill and neighbour-fill give different bytes. Repeating a vector with garbage in the upper shift bits, and idle cycles with changing inputs, show whether ignored bits and idle cycles leak into the output. Random data, amounts and directions sent back to back are then compared each clock against a behavioural model.

// File: rtl/lane_shift_pkg.sv
package lane_shift_pkg;

  // Strobes passed from control to datapath for one capture cycle
  typedef struct packed {
    logic capture;   // load the result register this edge
    logic goRight;   // direction of the captured operation
  } laneCtl_t;

endpackage

// File: rtl/lane_window.sv
// One lane: an 8-bit window taken out of a 16-bit neighbour pair
module lane_window #(
  parameter int LANE_W = 8,
  localparam int AMT_W = $clog2(LANE_W)
) (
  input  logic [LANE_W-1:0] curByte,
  input  logic [LANE_W-1:0] prevByte,   // lane i-1 (zero at lane 0)
  input  logic [LANE_W-1:0] nextByte,   // lane i+1 (zero at last lane)
  input  logic [AMT_W-1:0]  amt,
  input  logic              goRight,
  output logic [LANE_W-1:0] outByte
);

  logic [2*LANE_W-1:0] leftPair;
  logic [2*LANE_W-1:0] rightPair;
  logic [2*LANE_W-1:0] leftShifted;
  logic [2*LANE_W-1:0] rightShifted;

  always_comb begin
    leftPair     = {curByte, nextByte};
    rightPair    = {prevByte, curByte};
    leftShifted  = leftPair << amt;
    rightShifted = rightPair >> amt;
    if (goRight) outByte = rightShifted[LANE_W-1:0];
    else         outByte = leftShifted[2*LANE_W-1:LANE_W];
  end

endmodule

// File: rtl/lane_shift_ctrl.sv
// Control: turns the input strobe into datapath strobes and the valid flag
module lane_shift_ctrl
  import lane_shift_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     inValid,
  input  logic     dirRight,
  output laneCtl_t ctl,
  output logic     outValid
);

  logic validReg;

  always_comb begin
    ctl.capture = inValid & ~rst;
    ctl.goRight = dirRight;
  end

  always_ff @(posedge clk) begin
    if (rst) validReg <= 1'b0;
    else     validReg <= inValid;
  end

  assign outValid = validReg;

endmodule

// File: rtl/lane_shift_datapath.sv
// Datapath: one window per lane plus the result register
module lane_shift_datapath
  import lane_shift_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int AMT_W = $clog2(LANE_W)
) (
  input  logic          clk,
  input  logic          rst,
  input  laneCtl_t      ctl,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] shiftIn,
  output logic [DW-1:0] result
);

  logic [LANE_W-1:0] laneData [LANES];
  logic [AMT_W-1:0]  laneAmt  [LANES];
  logic [DW-1:0]     nextResult;
  logic [DW-1:0]     resReg;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] prevB;
    logic [LANE_W-1:0] nextB;
    logic [LANE_W-1:0] laneOut;

    // big-endian lane numbering: lane 0 is the top byte
    assign laneData[g] = dataIn[DW-1-g*LANE_W -: LANE_W];
    assign laneAmt[g]  = shiftIn[DW-(g+1)*LANE_W +: AMT_W];

    if (g == 0) begin : g_first
      assign prevB = '0;
    end else begin : g_mid_p
      assign prevB = laneData[g-1];
    end

    if (g == LANES-1) begin : g_last
      assign nextB = '0;
    end else begin : g_mid_n
      assign nextB = laneData[g+1];
    end

    lane_window #(.LANE_W(LANE_W)) u_win (
      .curByte (laneData[g]),
      .prevByte(prevB),
      .nextByte(nextB),
      .amt     (laneAmt[g]),
      .goRight (ctl.goRight),
      .outByte (laneOut)
    );

    assign nextResult[DW-1-g*LANE_W -: LANE_W] = laneOut;
  end

  always_ff @(posedge clk) begin
    if (rst)              resReg <= '0;
    else if (ctl.capture) resReg <= nextResult;
  end

  assign result = resReg;

endmodule

// File: rtl/byte_lane_shifter.sv
// Thin top: control plus datapath
module byte_lane_shifter
  import lane_shift_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inValid,
  input  logic          dirRight,
  input  logic [DW-1:0] dataIn,
  input  logic [DW-1:0] shiftIn,
  output logic [DW-1:0] result,
  output logic          outValid
);

  laneCtl_t ctl;

  lane_shift_ctrl u_ctrl (
    .clk     (clk),
    .rst     (rst),
    .inValid (inValid),
    .dirRight(dirRight),
    .ctl     (ctl),
    .outValid(outValid)
  );

  lane_shift_datapath #(.LANES(LANES), .LANE_W(LANE_W)) u_dp (
    .clk    (clk),
    .rst    (rst),
    .ctl    (ctl),
    .dataIn (dataIn),
    .shiftIn(shiftIn),
    .result (result)
  );

endmodule

// File: rtl/byte_lane_shifter_chk.sv
module byte_lane_shifter_chk #(
  parameter int LANES  = 16,
  parameter int LANE_W = 8,
  localparam int DW    = LANES * LANE_W,
  localparam int AMT_W = $clog2(LANE_W)
) (
  input logic          clk,
  input logic          rst,
  input logic          inValid,
  input logic          dirRight,
  input logic [DW-1:0] dataIn,
  input logic [DW-1:0] shiftIn,
  input logic [DW-1:0] result,
  input logic          outValid
);

  logic allZeroAmt;
  logic lastAmtMax;
  logic firstAmtMax;

  always_comb begin
    allZeroAmt = 1'b1;
    for (int i = 0; i < LANES; i++)
      if (shiftIn[i*LANE_W +: AMT_W] != '0) allZeroAmt = 1'b0;
    lastAmtMax  = (shiftIn[AMT_W-1:0] == AMT_W'(LANE_W-1));
    firstAmtMax = (shiftIn[DW-LANE_W +: AMT_W] == AMT_W'(LANE_W-1));
  end

  // R7
  valid_follows_chk: assert property (@(posedge clk) disable iff (rst)
    inValid |=> outValid);

  // R7
  no_spurious_valid_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> !outValid);

  // R8
  hold_result_chk: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> $stable(result));

  // R9
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!outValid && result == '0));

  // R6
  zero_amt_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && allZeroAmt) |=> (result == $past(dataIn)));

  // R4
  last_lane_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && !dirRight && lastAmtMax) |=>
      (result[LANE_W-1:0] == {$past(dataIn[0]), {(LANE_W-1){1'b0}}}));

  // R5
  first_lane_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (inValid && dirRight && firstAmtMax) |=>
      (result[DW-1 -: LANE_W] == {{(LANE_W-1){1'b0}}, $past(dataIn[DW-1])}));

endmodule

bind byte_lane_shifter byte_lane_shifter_chk #(.LANES(LANES), .LANE_W(LANE_W)) u_chk (.*);

// File: tb/byte_lane_shifter_test.sv
`timescale 1ns/1ps
module byte_lane_shifter_test;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         inValid = 1'b0;
  logic         dirRight = 1'b0;
  logic [127:0] dataIn = '0;
  logic [127:0] shiftIn = '0;
  logic [127:0] result;
  logic         outValid;

  int    vectors = 0;
  int    fails   = 0;
  string curReq  = "R9";

  logic [127:0] expRes = '0;
  logic         expVal = 1'b0;

  always #4 clk = ~clk;   // 125 MHz

  byte_lane_shifter uut (
    .clk(clk), .rst(rst), .inValid(inValid), .dirRight(dirRight),
    .dataIn(dataIn), .shiftIn(shiftIn), .result(result), .outValid(outValid)
  );

  // behavioural reference, written from the requirements
  function automatic logic [127:0] refShift(input logic [127:0] d,
                                            input logic [127:0] s,
                                            input logic right);
    logic [127:0] r = '0;
    for (int i = 0; i < 16; i++) begin
      int cur  = int'((d >> (8*(15-i))) & 128'hFF);
      int prv  = (i == 0)  ? 0 : int'((d >> (8*(16-i))) & 128'hFF);
      int nxt  = (i == 15) ? 0 : int'((d >> (8*(14-i))) & 128'hFF);
      int amt  = int'((s >> (8*(15-i))) & 128'h7);
      int outB;
      if (right) outB = (((prv << 8) | cur) >> amt) & 255;
      else       outB = (((cur << 8) | nxt) >> (8 - amt)) & 255;
      r = r | (128'(outB) << (8*(15-i)));
    end
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      expVal <= 1'b0;
      expRes <= '0;
    end else begin
      expVal <= inValid;
      if (inValid) expRes <= refShift(dataIn, shiftIn, dirRight);
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    vectors++;
    if (result !== expRes || outValid !== expVal) begin
      fails++;
      $display("FAIL %s model: result=%h valid=%b expected=%h valid=%b",
               curReq, result, outValid, expRes, expVal);
    end
  end

  task automatic checkLit(input string req, input logic [127:0] act,
                          input logic [127:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [127:0] d, input logic [127:0] s,
                       input logic right);
    dataIn = d; shiftIn = s; dirRight = right; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    summary();
    $finish;
  end

  initial begin
    logic [127:0] ramp;
    logic [127:0] r1;
    logic [127:0] noisy;
    logic [127:0] held;
    repeat (3) @(negedge clk);
    checkLit("R9", {127'b0, outValid}, 128'd0);
    checkLit("R9", result, 128'd0);
    rst = 1'b0;

    // R1 left ramp
    curReq = "R1";
    ramp = '0;
    for (int i = 0; i < 16; i++) ramp[8*(15-i) +: 8] = 8'(i);
    apply({16{8'h0F}}, ramp, 1'b0);
    checkLit("R1", result, 128'h0F1E3C78F0E1C3870F1E3C78F0E1C380);
    checkLit("R7", {127'b0, outValid}, 128'd1);

    // R2 right ramp
    curReq = "R2";
    for (int i = 0; i < 16; i++) ramp[8*(15-i) +: 8] = 8'(15 - i);
    apply({16{8'h0F}}, ramp, 1'b1);
    checkLit("R2", result, 128'h003C78F0E1C3870F1E3C78F0E1C3870F);

    // R4 / R5 edge lanes with amount 7
    curReq = "R4";
    apply({16{8'h0F}}, {16{8'h07}}, 1'b0);
    checkLit("R4", {120'b0, result[7:0]}, 128'h80);
    checkLit("R4", result, {{15{8'h87}}, 8'h80});
    curReq = "R5";
    apply({16{8'h0F}}, {16{8'h07}}, 1'b1);
    checkLit("R5", {120'b0, result[127:120]}, 128'h00);
    checkLit("R5", result, {8'h00, {15{8'h1E}}});

    // R6 zero amount
    curReq = "R6";
    apply(128'h0123456789ABCDEFFEDCBA9876543210, '0, 1'b0);
    checkLit("R6", result, 128'h0123456789ABCDEFFEDCBA9876543210);
    apply(128'hA5C3_0F1E_7788_99AA_5566_1234_DEAD_BEEF, '0, 1'b1);
    checkLit("R6", result, 128'hA5C3_0F1E_7788_99AA_5566_1234_DEAD_BEEF);

    // R3 upper shift bits ignored
    curReq = "R3";
    for (int i = 0; i < 16; i++) begin
      ramp[8*i +: 8]  = 8'(i % 8);
      noisy[8*i +: 8] = {5'($urandom()) | 5'b1, 3'(i % 8)};
    end
    apply({$urandom(), $urandom(), $urandom(), $urandom()}, ramp, 1'b0);
    r1 = result;
    dataIn = dataIn;
    apply(dataIn, noisy, 1'b0);
    checkLit("R3", result, r1);
    apply(dataIn, ramp, 1'b1);
    r1 = result;
    apply(dataIn, noisy, 1'b1);
    checkLit("R3", result, r1);

    // R7 valid drops one cycle after a single strobe
    curReq = "R7";
    @(negedge clk);
    checkLit("R7", {127'b0, outValid}, 128'd0);

    // R8 idle cycles with changing inputs
    curReq = "R8";
    held = result;
    for (int k = 0; k < 6; k++) begin
      dataIn   = {$urandom(), $urandom(), $urandom(), $urandom()};
      shiftIn  = {$urandom(), $urandom(), $urandom(), $urandom()};
      dirRight = 1'($urandom());
      @(negedge clk);
    end
    checkLit("R8", result, held);

    // random back-to-back traffic
    curReq = "R1";
    for (int k = 0; k < 300; k++) begin
      dataIn   = {$urandom(), $urandom(), $urandom(), $urandom()};
      shiftIn  = {$urandom(), $urandom(), $urandom(), $urandom()};
      dirRight = 1'($urandom());
      curReq   = dirRight ? "R2" : "R1";
      inValid  = ($urandom() % 4) != 0;
      @(negedge clk);
    end
    inValid = 1'b0;

    // R9 mid-stream reset
    curReq = "R9";
    apply({16{8'h3C}}, {16{8'h01}}, 1'b0);
    rst = 1'b1;
    inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
    checkLit("R9", result, 128'd0);
    checkLit("R9", {127'b0, outValid}, 128'd0);
    rst = 1'b0;
    @(negedge clk);

    summary();
    $finish;
  end

endmodule